// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

A purely combinational 16-bit adder that adds two operands and a carry-in and produces a 16-bit sum and a carry-out. It is split into four 4-bit slices. Each slice forms per-bit generate and propagate terms and derives its internal carries as fully expanded sums of products. It also reports a slice-wide propagate and generate pair. A separate lookahead carry unit combines the four slice pairs with the external carry-in. It returns the carry into each slice and the final carry-out, so no carry ever ripples from one slice to the next.

The same group equations, applied to the four slice pairs, give an adder-wide propagate and generate. Two or more adders can then be joined by a further lookahead level. A parameter selects whether the lookahead propagate term is the OR or the XOR of the operand bits. The sum and the carry-out do not depend on this choice. Sum bits always use the XOR of both operand bits and the incoming carry.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i`, taken as unsigned.
- R2: `c_o` equals bit 16 of the 17-bit unsigned result of `a_i + b_i + c_i`.
- R3: `gp_o` is 1 exactly when every bit position propagates. With the OR mode (`PROP_MODE = PROP_OR`) this means `&(a_i | b_i)`. With the XOR mode (`PROP_MODE = PROP_XOR`) it means `&(a_i ^ b_i)`.
- R4: `gg_o` is 1 exactly when `a_i + b_i` overflows 16 bits with no carry-in. This does not depend on the propagate mode.
- R5: `c_o` always equals `gg_o | (gp_o & c_i)`.
- R6: For equal inputs, `sum_o` and `c_o` are identical in the OR and XOR propagate modes.
- R7: When `a_i ^ b_i` is all ones, a carry-in of 1 crosses all four slices. The result is `sum_o = 0` and `c_o = 1`. With a carry-in of 0 the result is `sum_o = 16'hffff` and `c_o = 0`.
- R8: With both operands zero, `sum_o` equals `c_i` and `c_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |
| gp_o | output | 1 | Adder-wide group propagate |
| gg_o | output | 1 | Adder-wide group generate |

## Verification
The checker evaluates on every input change the arithmetic identity for the sum and carry-out, and the propagate and generate outputs against operand-level definitions. It also checks the consistency of `c_o` with the group pair and the full-width carry travel case. Equality of the two propagate modes involves two instances, so only the bench can show it. The bench also supplies the concrete corner cases: all ones plus one, alternating patterns, zero operands, and a carry generated in the lowest slice that must cross the upper three slices.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic {
    PROP_OR  = 1'b0,
    PROP_XOR = 1'b1
  } prop_mode_e;
endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int                  SLICE_W   = 4,
  parameter cla_pkg::prop_mode_e PROP_MODE = cla_pkg::PROP_OR
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               gp_o,
  output logic               gg_o
);
  logic [SLICE_W-1:0] gen, prop, half;
  logic [SLICE_W-1:0] cin_bit;

  assign gen  = a_i & b_i;
  assign half = a_i ^ b_i;

  generate
    if (PROP_MODE == cla_pkg::PROP_XOR) begin : g_prop_xor
      assign prop = a_i ^ b_i;
    end else begin : g_prop_or
      assign prop = a_i | b_i;
    end
  endgenerate

  // every carry is a flat sum of products over gen/prop/c_i
  always_comb begin
    logic acc, term;
    cin_bit[0] = c_i;
    for (int j = 1; j < SLICE_W; j++) begin
      term = c_i;
      for (int m = 0; m < j; m++) term = term & prop[m];
      acc = term;
      for (int k = 0; k < j; k++) begin
        term = gen[k];
        for (int m = k + 1; m < j; m++) term = term & prop[m];
        acc = acc | term;
      end
      cin_bit[j] = acc;
    end
  end

  always_comb begin
    logic acc, term;
    acc = 1'b0;
    for (int k = 0; k < SLICE_W; k++) begin
      term = gen[k];
      for (int m = k + 1; m < SLICE_W; m++) term = term & prop[m];
      acc = acc | term;
    end
    gg_o = acc;
  end

  assign gp_o  = &prop;
  assign sum_o = half ^ cin_bit;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N_GRP = 4
) (
  input  logic [N_GRP-1:0] g_i,
  input  logic [N_GRP-1:0] p_i,
  input  logic             c_i,
  output logic [N_GRP-1:0] c_grp_o,
  output logic             c_o,
  output logic             gp_o,
  output logic             gg_o
);
  logic [N_GRP:0] carry;

  // carry[j]: flat SOP, no dependence on carry[j-1]
  always_comb begin
    logic acc, term;
    carry[0] = c_i;
    for (int j = 1; j <= N_GRP; j++) begin
      term = c_i;
      for (int m = 0; m < j; m++) term = term & p_i[m];
      acc = term;
      for (int k = 0; k < j; k++) begin
        term = g_i[k];
        for (int m = k + 1; m < j; m++) term = term & p_i[m];
        acc = acc | term;
      end
      carry[j] = acc;
    end
  end

  always_comb begin
    logic acc, term;
    acc = 1'b0;
    for (int k = 0; k < N_GRP; k++) begin
      term = g_i[k];
      for (int m = k + 1; m < N_GRP; m++) term = term & p_i[m];
      acc = acc | term;
    end
    gg_o = acc;
  end

  assign gp_o    = &p_i;
  assign c_grp_o = carry[N_GRP-1:0];
  assign c_o     = carry[N_GRP];
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int                  WIDTH     = 16,
  parameter int                  SLICE_W   = 4,
  parameter cla_pkg::prop_mode_e PROP_MODE = cla_pkg::PROP_OR
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             gp_o,
  output logic             gg_o
);
  localparam int NUM_SLICES = WIDTH / SLICE_W;

  logic [NUM_SLICES-1:0] slice_gp, slice_gg, slice_cin;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cla_slice #(
      .SLICE_W  (SLICE_W),
      .PROP_MODE(PROP_MODE)
    ) i_slice (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_i[s*SLICE_W +: SLICE_W]),
      .c_i  (slice_cin[s]),
      .sum_o(sum_o[s*SLICE_W +: SLICE_W]),
      .gp_o (slice_gp[s]),
      .gg_o (slice_gg[s])
    );
  end

  cla_lookahead #(
    .N_GRP(NUM_SLICES)
  ) i_lookahead (
    .g_i    (slice_gg),
    .p_i    (slice_gp),
    .c_i    (c_i),
    .c_grp_o(slice_cin),
    .c_o    (c_o),
    .gp_o   (gp_o),
    .gg_o   (gg_o)
  );
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int                  WIDTH     = 16,
  parameter cla_pkg::prop_mode_e PROP_MODE = cla_pkg::PROP_OR
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             c_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             c_o,
  input logic             gp_o,
  input logic             gg_o
);
  logic [WIDTH:0] ref_full, ref_nocin;
  logic           ref_gp;

  always_comb begin
    ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
    ref_nocin = {1'b0, a_i} + {1'b0, b_i};
    ref_gp    = (PROP_MODE == cla_pkg::PROP_XOR) ? &(a_i ^ b_i) : &(a_i | b_i);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      assert_sum_R1 : assert (sum_o == ref_full[WIDTH-1:0]);
      assert_carry_out_R2 : assert (c_o == ref_full[WIDTH]);
      assert_group_prop_R3 : assert (gp_o == ref_gp);
      assert_group_gen_R4 : assert (gg_o == ref_nocin[WIDTH]);
      assert_cout_groups_R5 : assert (c_o == (gg_o | (gp_o & c_i)));
      if (&(a_i ^ b_i)) begin
        assert_full_travel_R7 : assert ({c_o, sum_o} == (c_i ? {1'b1, {WIDTH{1'b0}}} : {1'b0, {WIDTH{1'b1}}}));
      end
      if (a_i == '0 && b_i == '0) begin
        assert_zero_ops_R8 : assert (c_o == 1'b0 && sum_o == {{(WIDTH-1){1'b0}}, c_i});
      end
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(
  .WIDTH    (WIDTH),
  .PROP_MODE(PROP_MODE)
) i_cla16_adder_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .c_i  (c_i),
  .sum_o(sum_o),
  .c_o  (c_o),
  .gp_o (gp_o),
  .gg_o (gg_o)
);

// File: tb/test_cla16_adder.sv
module test_cla16_adder;
  localparam int W  = 16;
  localparam int NV = 12;

  // {a, b, cin}
  localparam logic [2*W:0] VEC [NV] = '{
    {16'hffff, 16'h0000, 1'b1},
    {16'hffff, 16'h0001, 1'b0},
    {16'haaaa, 16'h5555, 1'b0},
    {16'haaaa, 16'h5555, 1'b1},
    {16'haaaa, 16'haaaa, 1'b0},
    {16'h5555, 16'h5555, 1'b1},
    {16'hfff1, 16'h000f, 1'b0},
    {16'h0fff, 16'h0001, 1'b0},
    {16'h8000, 16'h8000, 1'b0},
    {16'hffff, 16'hffff, 1'b1},
    {16'h1234, 16'h4321, 1'b1},
    {16'h7fff, 16'h0000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic cin;
  logic [W-1:0] sum_or, sum_x;
  logic cout_or, cout_x, gp_or, gp_x, gg_or, gg_x;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cla16_adder #(.PROP_MODE(cla_pkg::PROP_OR)) i_cla16_adder (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(sum_or), .c_o(cout_or), .gp_o(gp_or), .gg_o(gg_or)
  );

  cla16_adder #(.PROP_MODE(cla_pkg::PROP_XOR)) i_cla16_adder_x (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(sum_x), .c_o(cout_x), .gp_o(gp_x), .gg_o(gg_x)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h cin=%0d act=%h exp=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    logic [W:0] full, nocin;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    full  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    nocin = {1'b0, va} + {1'b0, vb};
    chk("R1 sum", {16'h0, sum_or}, {16'h0, full[W-1:0]});
    chk("R2 cout", {31'h0, cout_or}, {31'h0, full[W]});
    chk("R3 gp or-mode", {31'h0, gp_or}, {31'h0, &(va | vb)});
    chk("R3 gp xor-mode", {31'h0, gp_x}, {31'h0, &(va ^ vb)});
    chk("R4 gg", {30'h0, gg_or, gg_x}, {30'h0, nocin[W], nocin[W]});
    chk("R5 cout vs groups", {31'h0, cout_x}, {31'h0, gg_x | (gp_x & vc)});
    chk("R6 modes agree", {15'h0, cout_x, sum_x}, {15'h0, cout_or, sum_or});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 idle zero sum", {16'h0, sum_or}, 32'h0);
    chk("R8 idle zero cout", {31'h0, cout_or}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);

    // R7: carry crosses all four slices
    apply(16'hffff, 16'h0000, 1'b1);
    chk("R7 travel sum", {16'h0, sum_x}, 32'h0);
    chk("R7 travel cout", {31'h0, cout_x}, 32'h1);
    apply(16'h0f0f, 16'hf0f0, 1'b0);
    chk("R7 no-cin sum", {16'h0, sum_or}, 32'hffff);
    chk("R7 no-cin cout", {31'h0, cout_or}, 32'h0);
    // carry generated in lowest slice, propagated through upper three
    apply(16'hfff8, 16'h0008, 1'b0);
    chk("R7 low-gen sum", {16'h0, sum_or}, 32'h0);
    chk("R7 low-gen cout", {31'h0, cout_or}, 32'h1);

    // R8: zero operands
    apply(16'h0000, 16'h0000, 1'b1);
    chk("R8 zero sum", {16'h0, sum_or}, 32'h1);
    chk("R8 zero cout", {31'h0, cout_or}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[31:16], r[15:0], 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule